// File: doc/BRIEF.md
# S/PDIF Transmit Frame Encoder

This block turns a stream of stereo 24-bit samples into a bi-phase-mark coded serial line. Each frame carries a left and a right sub-frame. Every sub-frame starts with a four-slot synchronisation preamble, and the preamble deliberately breaks the coding rule. After the preamble come 28 data slots: the sample, a validity flag, a user bit held at zero, one bit of a host-supplied 192-bit channel-status word, and an even parity bit. Frames are counted so that a block-start preamble appears exactly once every 192 frames.

Line timing comes entirely from `cell_en`. This is a one-cycle enable, supplied from outside, that pulses at twice the bit rate. Each pulse advances the line by one half-cell, so one sub-frame takes 64 pulses. Samples arrive through a ready/valid handshake, and a new stereo pair is taken once per frame, just before the left sub-frame starts. If no sample is offered at that moment, the next frame carries zero data with both validity flags set.

Top module: `spdif_tx_encoder`

## Requirements
- R1: Slots 4..31 of a sub-frame are bi-phase-mark coded. The line toggles at the start of every slot, and toggles again at mid-slot exactly when the bit is 1.
- R2: Slots 0..3 carry a preamble, given as eight half-cell levels with the first one leftmost. The block-start pattern 11101000 is used for the left sub-frame of frame 0. The left pattern 11100010 is used for every other left sub-frame. The right pattern 11100100 is used for every right sub-frame. All three patterns are inverted when the line was high before the sub-frame.
- R3: The frame index counts 0..FRAMES_PER_BLOCK-1 and then wraps, so the block-start preamble recurs every 192 frames.
- R4: Slots 4..27 carry sample bits 0..23 in that order, LSB first. The low four bits form the auxiliary field.
- R5: Slot 28 carries the validity flag of that channel, where 1 means invalid.
- R6: Slot 29, the user bit, is always 0.
- R7: Slot 30 carries `chan_status[f]`, where f is the current frame index. Both sub-frames of a frame use the same bit.
- R8: Slot 31 makes the count of ones over slots 4..31 even. As a result, the line level at the end of every sub-frame equals the level at its start.
- R9: `s_ready` is high only in the cycle in which `cell_en` advances out of the last half-cell of a frame. A sample accepted there is sent in the next frame, with left on the first sub-frame and right on the second.
- R10: If `s_valid` is low while `s_ready` is high, the next frame sends zero data with validity 1 on both channels.
- R11: During and after reset, `spdif_out` is 0 and `s_ready` is 0. The first frame is frame 0 with a block-start preamble, zero data and validity 1.
- R12: `spdif_out` changes only on clock edges where `cell_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_en | input | 1 | Half-cell advance enable |
| chan_status | input | FRAMES_PER_BLOCK | Channel-status block, bit f sent in frame f |
| s_valid | input | 1 | Stereo sample offered |
| s_ready | output | 1 | Sample taken this cycle |
| s_left | input | 24 | Left sample |
| s_left_invalid | input | 1 | Left validity flag (1 = invalid) |
| s_right | input | 24 | Right sample |
| s_right_invalid | input | 1 | Right validity flag (1 = invalid) |
| spdif_out | output | 1 | Bi-phase-mark coded line |

## Verification
A half-cell counter that slips corrupts the decode of the very sub-frame it happens in. It shows at once as a missing slot-boundary transition, or as a preamble pattern at a half-cell where data is expected. A frame counter that is off by one moves the block-start preamble and the channel-status bit away from their expected frame within one block of 192 frames. A parity or polarity fault shows in the same sub-frame, as a line level that differs from the start level at the sub-frame boundary. A handshake timed in the wrong cycle sends the wrong sample in the very next frame.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int SAMPLE_W     = 24;
    localparam int HALF_PER_SUB = 64;
    localparam int PRE_HALVES   = 8;
    localparam int PAYLOAD_W    = 28;

    typedef enum logic [1:0] {
        PRE_BLOCK,
        PRE_LEFT,
        PRE_RIGHT
    } pre_kind_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                invalid;
    } chan_word_t;

    typedef struct packed {
        chan_word_t right;
        chan_word_t left;
    } stereo_t;

    localparam chan_word_t IDLE_WORD = '{data: '0, invalid: 1'b1};

    // Half-cell levels for a line that was low before the preamble; MSB goes first.
    function automatic logic [7:0] pre_pattern(pre_kind_e kind);
        case (kind)
            PRE_BLOCK: return 8'b1110_1000;
            PRE_LEFT:  return 8'b1110_0010;
            default:   return 8'b1110_0100;
        endcase
    endfunction

    // Slots 4..31: sample, validity, user (0), channel status, even parity.
    function automatic logic [PAYLOAD_W-1:0] build_payload(chan_word_t w, logic cs_bit);
        logic [PAYLOAD_W-2:0] body;
        body = {cs_bit, 1'b0, w.invalid, w.data};
        return {^body, body};
    endfunction

endpackage

// File: rtl/spdif_tx_sequencer.sv
module spdif_tx_sequencer #(
    parameter int FRAMES = 192,
    localparam int FW = $clog2(FRAMES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cell_en,
    output logic [5:0]    half_idx,
    output logic          second_sub,
    output logic [FW-1:0] frame_idx,
    output logic          frame_end
);
    import spdif_tx_pkg::*;

    localparam logic [5:0] LAST_HALF = 6'(HALF_PER_SUB - 1);
    localparam logic [FW-1:0] LAST_FRAME = FW'(FRAMES - 1);

    assign frame_end = cell_en && second_sub && (half_idx == LAST_HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            half_idx   <= '0;
            second_sub <= 1'b0;
            frame_idx  <= '0;
        end else if (cell_en) begin
            if (half_idx == LAST_HALF) begin
                half_idx   <= '0;
                second_sub <= ~second_sub;
                if (second_sub) begin
                    frame_idx <= (frame_idx == LAST_FRAME) ? '0 : frame_idx + 1'b1;
                end
            end else begin
                half_idx <= half_idx + 1'b1;
            end
        end
    end

    // R3: the last frame of a block is followed by frame 0
    assert_block_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_end && frame_idx == LAST_FRAME) |=> (frame_idx == '0));

endmodule

// File: rtl/spdif_tx_sample_hold.sv
module spdif_tx_sample_hold (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   s_valid,
    input  spdif_tx_pkg::stereo_t  offered,
    output spdif_tx_pkg::stereo_t  current
);
    import spdif_tx_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            current <= '{right: IDLE_WORD, left: IDLE_WORD};
        end else if (load) begin
            current <= s_valid ? offered : '{right: IDLE_WORD, left: IDLE_WORD};
        end
    end

endmodule

// File: rtl/spdif_tx_bmc.sv
module spdif_tx_bmc (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 cell_en,
    input  logic [5:0]                           half_idx,
    input  spdif_tx_pkg::pre_kind_e              pre_kind,
    input  logic [spdif_tx_pkg::PAYLOAD_W-1:0]   payload,
    output logic                                 line
);
    import spdif_tx_pkg::*;

    logic       line_q;
    logic       start_lvl_q;
    logic       pol;
    logic [7:0] pat;
    logic [4:0] pidx;
    logic       next_line;

    assign pol  = (half_idx == 6'd0) ? line_q : start_lvl_q;
    assign pat  = pre_pattern(pre_kind);
    assign pidx = half_idx[5:1] - 5'd4;

    always_comb begin
        if (half_idx < 6'(PRE_HALVES)) begin
            next_line = pat[~half_idx[2:0]] ^ pol;
        end else if (!half_idx[0]) begin
            next_line = ~line_q;
        end else begin
            next_line = line_q ^ payload[pidx];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q      <= 1'b0;
            start_lvl_q <= 1'b0;
        end else if (cell_en) begin
            line_q <= next_line;
            if (half_idx == 6'd0) begin
                start_lvl_q <= line_q;
            end
        end
    end

    assign line = line_q;

    // R1: every data slot opens with a transition
    assert_slot_edge_R1: assert property (@(posedge clk) disable iff (rst)
        (cell_en && half_idx >= 6'(PRE_HALVES) && !half_idx[0]) |=> (line_q != $past(line_q)));

    // R8: even parity returns the line to the sub-frame's starting level
    assert_even_end_R8: assert property (@(posedge clk) disable iff (rst)
        (cell_en && half_idx == 6'(HALF_PER_SUB - 1)) |=> (line_q == start_lvl_q));

    // R12: no movement without a half-cell enable
    assert_line_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !cell_en |=> $stable(line_q));

endmodule

// File: rtl/spdif_tx_encoder.sv
module spdif_tx_encoder #(
    parameter int FRAMES_PER_BLOCK = 192
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cell_en,
    input  logic [FRAMES_PER_BLOCK-1:0] chan_status,
    input  logic                        s_valid,
    output logic                        s_ready,
    input  logic [23:0]                 s_left,
    input  logic                        s_left_invalid,
    input  logic [23:0]                 s_right,
    input  logic                        s_right_invalid,
    output logic                        spdif_out
);
    import spdif_tx_pkg::*;

    localparam int FW = $clog2(FRAMES_PER_BLOCK);

    logic [5:0]           half_idx;
    logic                 second_sub;
    logic [FW-1:0]        frame_idx;
    logic                 frame_end;
    stereo_t              offered;
    stereo_t              current;
    chan_word_t           word;
    pre_kind_e            kind;
    logic [PAYLOAD_W-1:0] payload;

    spdif_tx_sequencer #(.FRAMES(FRAMES_PER_BLOCK)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cell_en    (cell_en),
        .half_idx   (half_idx),
        .second_sub (second_sub),
        .frame_idx  (frame_idx),
        .frame_end  (frame_end)
    );

    assign offered = '{right: '{data: s_right, invalid: s_right_invalid},
                       left:  '{data: s_left,  invalid: s_left_invalid}};
    assign s_ready = frame_end;

    spdif_tx_sample_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .load    (frame_end),
        .s_valid (s_valid),
        .offered (offered),
        .current (current)
    );

    always_comb begin
        if (second_sub)            kind = PRE_RIGHT;
        else if (frame_idx == '0)  kind = PRE_BLOCK;
        else                       kind = PRE_LEFT;
    end

    assign word    = second_sub ? current.right : current.left;
    assign payload = build_payload(word, chan_status[frame_idx]);

    spdif_tx_bmc u_bmc (
        .clk      (clk),
        .rst      (rst),
        .cell_en  (cell_en),
        .half_idx (half_idx),
        .pre_kind (kind),
        .payload  (payload),
        .line     (spdif_out)
    );

    // R9: an accepted sample is followed by the left sub-frame's first half-cell
    assert_take_point_R9: assert property (@(posedge clk) disable iff (rst)
        s_ready |=> (half_idx == 6'd0 && !second_sub));

    // R9: the handshake only happens on a half-cell advance
    assert_ready_on_cell_R9: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> cell_en);

endmodule

// File: tb/tb_spdif_tx_encoder.sv
module tb_spdif_tx_encoder;
    import spdif_tx_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FRAMES     = 192;
    localparam int RUN_FRAMES = 200;
    localparam logic [FRAMES-1:0] CS_WORD = {6{32'hC35A_0F96}};

    logic        clk = 1'b0;
    logic        rst;
    logic        cell_en;
    logic [FRAMES-1:0] chan_status;
    logic        s_valid;
    logic        s_ready;
    logic [23:0] s_left;
    logic        s_left_invalid;
    logic [23:0] s_right;
    logic        s_right_invalid;
    logic        spdif_out;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spdif_tx_encoder #(.FRAMES_PER_BLOCK(FRAMES)) dut (
        .clk             (clk),
        .rst             (rst),
        .cell_en         (cell_en),
        .chan_status     (chan_status),
        .s_valid         (s_valid),
        .s_ready         (s_ready),
        .s_left          (s_left),
        .s_left_invalid  (s_left_invalid),
        .s_right         (s_right),
        .s_right_invalid (s_right_invalid),
        .spdif_out       (spdif_out)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] left_of(int f);
        logic [31:0] t;
        t = f * 32'h9E37_79B1 + 32'h0012_3457;
        return t[31:8];
    endfunction

    function automatic logic [23:0] right_of(int f);
        logic [31:0] t;
        t = (f + 17) * 32'h85EB_CA6B;
        return t[23:0] ^ 24'hF0F00F;
    endfunction

    logic       lvbuf [0:63];
    logic       end_level;
    logic       level_prev;
    chan_word_t cur_l, cur_r, nxt_l, nxt_r;

    task automatic process_sub(input int fr, input int sb);
        logic [7:0]  got_pre, exp_pre;
        logic [27:0] dec, exp_bits;
        logic        edges_ok;
        logic        prior;
        int          bf;
        chan_word_t  w;
        bf = fr % FRAMES;
        w  = sb ? cur_r : cur_l;
        for (int k = 0; k < 8; k++) got_pre[7-k] = lvbuf[k];
        if (sb == 1)      exp_pre = 8'b1110_0100;
        else if (bf == 0) exp_pre = 8'b1110_1000;
        else              exp_pre = 8'b1110_0010;
        exp_pre = exp_pre ^ {8{end_level}};
        if (sb == 0 && bf == 0 && fr != 0)
            check(got_pre == exp_pre, "R3 block-start preamble after wrap", 32'(got_pre), 32'(exp_pre));
        else
            check(got_pre == exp_pre, "R2 preamble pattern", 32'(got_pre), 32'(exp_pre));

        edges_ok = 1'b1;
        for (int j = 0; j < 28; j++) begin
            prior = (j == 0) ? lvbuf[7] : lvbuf[7+2*j];
            if (lvbuf[8+2*j] == prior) edges_ok = 1'b0;
            dec[j] = lvbuf[8+2*j] ^ lvbuf[9+2*j];
        end
        check(edges_ok, "R1 slot boundary transitions", 32'(edges_ok), 32'd1);

        for (int j = 0; j < 24; j++) exp_bits[j] = w.data[j];
        exp_bits[24] = w.invalid;
        exp_bits[25] = 1'b0;
        exp_bits[26] = CS_WORD[bf];
        exp_bits[27] = 1'b0;
        for (int j = 0; j < 27; j++) exp_bits[27] = exp_bits[27] ^ exp_bits[j];

        check(dec[23:0] == exp_bits[23:0], "R4 sample bits LSB first", 32'(dec[23:0]), 32'(exp_bits[23:0]));
        check(dec[24] == exp_bits[24], "R5 validity slot", 32'(dec[24]), 32'(exp_bits[24]));
        check(dec[25] == 1'b0, "R6 user slot", 32'(dec[25]), 32'd0);
        check(dec[26] == exp_bits[26], "R7 channel-status slot", 32'(dec[26]), 32'(exp_bits[26]));
        check(dec[27] == exp_bits[27], "R8 parity slot", 32'(dec[27]), 32'(exp_bits[27]));
        check(lvbuf[63] == end_level, "R8 sub-frame end level", 32'(lvbuf[63]), 32'(end_level));
        if (fr == 0)
            check(dec[24:0] == {1'b1, 24'h0}, "R11 first frame idle data", 32'(dec[24:0]), 32'h0100_0000);
        else if (((fr - 1) % 7) == 3)
            check(dec[24:0] == {1'b1, 24'h0}, "R10 no-sample frame", 32'(dec[24:0]), 32'h0100_0000);
        end_level = lvbuf[63];
    endtask

    initial begin
        rst = 1'b1;
        cell_en = 1'b0;
        s_valid = 1'b0;
        s_left = '0;
        s_right = '0;
        s_left_invalid = 1'b0;
        s_right_invalid = 1'b0;
        chan_status = CS_WORD;
        repeat (4) @(negedge clk);
        check(spdif_out == 1'b0, "R11 reset line level", 32'(spdif_out), 32'd0);
        check(s_ready == 1'b0, "R11 reset ready", 32'(s_ready), 32'd0);
        rst = 1'b0;
        end_level  = 1'b0;
        level_prev = 1'b0;
        cur_l = IDLE_WORD;
        cur_r = IDLE_WORD;
        nxt_l = IDLE_WORD;
        nxt_r = IDLE_WORD;

        for (int n = 0; n < RUN_FRAMES * 128; n++) begin
            int fr;
            int hf;
            int sb;
            fr = n / 128;
            hf = n % 64;
            sb = (n / 64) % 2;
            @(negedge clk);
            s_valid         = ((fr % 7) != 3);
            s_left          = left_of(fr);
            s_right         = right_of(fr);
            s_left_invalid  = ((fr % 5) == 0);
            s_right_invalid = ((fr % 11) == 0);
            cell_en = 1'b1;
            #1;
            check(spdif_out == level_prev, "R12 line held while enable low", 32'(spdif_out), 32'(level_prev));
            check(s_ready == ((n % 128) == 127), "R9 ready timing", 32'(s_ready), 32'((n % 128) == 127));
            if ((n % 128) == 127) begin
                if (s_valid) begin
                    nxt_l = '{data: s_left,  invalid: s_left_invalid};
                    nxt_r = '{data: s_right, invalid: s_right_invalid};
                end else begin
                    nxt_l = IDLE_WORD;
                    nxt_r = IDLE_WORD;
                end
            end
            @(negedge clk);
            cell_en = 1'b0;
            lvbuf[hf] = spdif_out;
            level_prev = spdif_out;
            if (hf == 63) process_sub(fr, sb);
            if ((n % 128) == 127) begin
                cur_l = nxt_l;
                cur_r = nxt_r;
            end
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule